// File: doc/BRIEF.md
# Wired-Priority Bus Arbitration Agent

This block is one contender's half of a distributed arbitration scheme on a shared parallel bus. The bus has no central arbiter. Every agent pulls open-drain priority lines low to show its own numeric identifier. Each agent watches the wired result and backs off on the lower-order lines as soon as it sees that a more important agent is present. After a fixed number of settling clocks, the one agent whose identifier equals the resolved value owns the bus.

The identifier is not strapped. While the system is still initialising, a central controller places a value on the same priority lines, and the agent captures it on its own slot strobe. A local requester raises `req_i`. The agent then pulls the shared request line low, waits until the bus is idle, and contends. If it wins, it returns `grant_o` and keeps its identifier on the lines until the requester lets go and the current transfer has finished. An agent that loses keeps the shared request line asserted and contends again as soon as the owner releases.

All the lines are modelled with separate input level, output value and output enable signals. A line is low whenever any agent enables its driver.

Top module: `wired_arb_agent`

## Requirements
- R1: While `rst` is high, `grant_o`, `breq_oe_o` and every bit of `arb_oe_o` are 0 from the next clock edge on.
- R2: On an edge where `init_busy_i` and `id_latch_i` are both high, the identifier is loaded as the inverted line levels: bit i is 1 when `arb_in_i[i]` is low. An owner drives `arb_oe_o` equal to that identifier (enable bit set means that line is pulled low).
- R3: While `init_busy_i` is high, `req_i` is ignored. `grant_o`, `breq_oe_o` and `arb_oe_o` stay 0, and the agent returns to idle.
- R4: When `req_i` is high in idle, `breq_oe_o` is 1 after the next edge. It stays 1 until ownership is released or `req_i` drops before ownership.
- R5: Contention starts on the first edge where `breq_in_i` is low, every `arb_in_i` bit is high and `xfer_active_i` is low. On that edge the full identifier is placed on `arb_oe_o`. It never starts while `xfer_active_i` is high.
- R6: While contending, an identifier bit stays enabled only if no more-significant line reads low where the agent's own bit is 0. Between two agents with distinct identifiers, the numerically larger one wins.
- R7: With the bus idle, a winner's `grant_o` rises exactly SETTLE+3 edges after `req_i` is raised (5 with SETTLE=2). The grant is given only when the resolved value (inverted `arb_in_i`) equals the identifier.
- R8: An owner keeps `grant_o` and a steady `arb_oe_o` while `req_i` or `xfer_active_i` is high. On the first edge with both low, it clears `grant_o`, `arb_oe_o` and `breq_oe_o`.
- R9: A losing agent releases `arb_oe_o` to 0 and keeps `breq_oe_o` at 1. After the owner's release edge it is granted exactly SETTLE+2 edges later (4 with SETTLE=2).
- R10: `arb_out_o` and `breq_out_o` are always 0, so an enabled driver always pulls its line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_busy_i | input | 1 | High while system initialisation is not complete |
| id_latch_i | input | 1 | Slot strobe that captures the identifier during initialisation |
| req_i | input | 1 | Local request for bus ownership |
| grant_o | output | 1 | Local grant, high while this agent owns the bus |
| xfer_active_i | input | 1 | High while a bus transfer is in progress |
| breq_in_i | input | 1 | Level of the shared bus-request line (low = some agent requesting) |
| breq_out_o | output | 1 | Value driven on the bus-request line when enabled (always 0) |
| breq_oe_o | output | 1 | Driver enable for the bus-request line |
| arb_in_i | input | ID_W | Levels of the priority lines |
| arb_out_o | output | ID_W | Values driven on the priority lines when enabled (always 0) |
| arb_oe_o | output | ID_W | Per-line driver enables for the priority lines |

## Verification
Every output is registered, so each result is due a fixed number of edges after its stimulus. `breq_oe_o` follows one edge after the request. A contested grant comes SETTLE+3 edges after the request, and a release comes one edge after `req_i` and `xfer_active_i` are both low. The loser's grant comes SETTLE+2 edges after that release edge. The bench joins two agents through a wired-low line model. It sweeps every ordered pair of distinct nonzero 5-bit identifiers and predicts the winner as the larger value. Inputs change on the falling edge, and each output is sampled on the falling edge in its due cycle and also in the cycle just before it, so a grant that arrives early or late is reported.

// File: rtl/wired_arb_pkg.sv
package wired_arb_pkg;
  typedef enum logic [1:0] {
    AG_IDLE,
    AG_WAIT,
    AG_CONTEND,
    AG_OWN
  } agent_state_e;
endpackage

// File: rtl/wired_arb_idcap.sv
// Captures the agent identifier from the priority lines during initialisation.
module wired_arb_idcap #(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture_i,
  input  logic [ID_W-1:0] lines_i,
  output logic [ID_W-1:0] id_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_o <= '0;
    end else if (capture_i) begin
      id_o <= ~lines_i;  // a low line carries a 1
    end
  end
endmodule

// File: rtl/wired_arb_resolve.sv
// Per-bit back-off mask and win detection against the wired result.
module wired_arb_resolve #(
  parameter int ID_W = 5
) (
  input  logic [ID_W-1:0] my_id_i,
  input  logic [ID_W-1:0] lines_i,
  output logic [ID_W-1:0] drive_mask_o,
  output logic            won_o
);
  logic [ID_W-1:0] resolved;
  logic [ID_W-1:0] beaten;  // beaten[i]: a stronger agent shows above bit i

  assign resolved = ~lines_i;
  assign beaten[ID_W-1] = 1'b0;

  for (genvar i = ID_W - 2; i >= 0; i--) begin : g_chain
    assign beaten[i] = beaten[i+1] | (resolved[i+1] & ~my_id_i[i+1]);
  end

  for (genvar i = 0; i < ID_W; i++) begin : g_mask
    assign drive_mask_o[i] = my_id_i[i] & ~beaten[i];
  end

  assign won_o = (resolved == my_id_i);
endmodule

// File: rtl/wired_arb_agent.sv
module wired_arb_agent
  import wired_arb_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int SETTLE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_busy_i,
  input  logic            id_latch_i,
  input  logic            req_i,
  output logic            grant_o,
  input  logic            xfer_active_i,
  input  logic            breq_in_i,
  output logic            breq_out_o,
  output logic            breq_oe_o,
  input  logic [ID_W-1:0] arb_in_i,
  output logic [ID_W-1:0] arb_out_o,
  output logic [ID_W-1:0] arb_oe_o
);
  localparam int CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE);

  agent_state_e    state_q;
  logic [CNT_W-1:0] cnt_q;
  logic            grant_q;
  logic            breq_q;
  logic [ID_W-1:0] drive_q;
  logic [ID_W-1:0] my_id;
  logic [ID_W-1:0] drive_mask;
  logic            won;
  logic            bus_free;

  wired_arb_idcap #(.ID_W(ID_W)) u_idcap (
    .clk       (clk),
    .rst       (rst),
    .capture_i (init_busy_i & id_latch_i),
    .lines_i   (arb_in_i),
    .id_o      (my_id)
  );

  wired_arb_resolve #(.ID_W(ID_W)) u_resolve (
    .my_id_i      (my_id),
    .lines_i      (arb_in_i),
    .drive_mask_o (drive_mask),
    .won_o        (won)
  );

  // Idle bus: someone requests, no priority line pulled, no transfer running.
  assign bus_free = !breq_in_i && (&arb_in_i) && !xfer_active_i;

  always_ff @(posedge clk) begin
    if (rst || init_busy_i) begin
      state_q <= AG_IDLE;
      cnt_q   <= '0;
      grant_q <= 1'b0;
      breq_q  <= 1'b0;
      drive_q <= '0;
    end else begin
      unique case (state_q)
        AG_IDLE: begin
          if (req_i) begin
            state_q <= AG_WAIT;
            breq_q  <= 1'b1;
          end
        end
        AG_WAIT: begin
          if (!req_i) begin
            state_q <= AG_IDLE;
            breq_q  <= 1'b0;
          end else if (bus_free) begin
            state_q <= AG_CONTEND;
            drive_q <= my_id;
            cnt_q   <= '0;
          end
        end
        AG_CONTEND: begin
          if (cnt_q == CNT_LAST) begin
            if (won) begin
              state_q <= AG_OWN;
              grant_q <= 1'b1;
              drive_q <= my_id;
            end else begin
              state_q <= AG_WAIT;
              drive_q <= '0;
            end
          end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            drive_q <= drive_mask;
          end
        end
        AG_OWN: begin
          if (!req_i && !xfer_active_i) begin
            state_q <= AG_IDLE;
            grant_q <= 1'b0;
            breq_q  <= 1'b0;
            drive_q <= '0;
          end
        end
        default: state_q <= AG_IDLE;
      endcase
    end
  end

  assign grant_o    = grant_q;
  assign breq_oe_o  = breq_q;
  assign breq_out_o = 1'b0;
  assign arb_oe_o   = drive_q;
  assign arb_out_o  = '0;
endmodule

// File: rtl/wired_arb_agent_chk.sv
module wired_arb_agent_chk #(
  parameter int ID_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            init_busy_i,
  input logic            req_i,
  input logic            xfer_active_i,
  input logic            breq_in_i,
  input logic [ID_W-1:0] arb_in_i,
  input logic            grant_o,
  input logic            breq_oe_o,
  input logic [ID_W-1:0] arb_oe_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!grant_o && !breq_oe_o && arb_oe_o == '0));

  p_init_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    init_busy_i |=> (!grant_o && !breq_oe_o && arb_oe_o == '0));

  p_grant_needs_breq_r4: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    $rose(grant_o) |-> $past(breq_oe_o));

  p_start_cond_r5: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    (arb_oe_o != '0 && $past(arb_oe_o) == '0) |->
      ($past(!xfer_active_i) && $past(&arb_in_i) && $past(!breq_in_i)));

  p_win_match_r7: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    $rose(grant_o) |-> ($past(~arb_in_i) == arb_oe_o));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    (grant_o && (req_i || xfer_active_i)) |=> grant_o);

  p_own_steady_r8: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    (grant_o && $past(grant_o)) |-> $stable(arb_oe_o));

  p_release_r8: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    (grant_o && !req_i && !xfer_active_i) |=>
      (!grant_o && !breq_oe_o && arb_oe_o == '0));

  p_loser_keeps_breq_r9: assert property (@(posedge clk) disable iff (rst || init_busy_i)
    ($fell(|arb_oe_o) && !$past(grant_o)) |-> breq_oe_o);
endmodule

bind wired_arb_agent wired_arb_agent_chk #(.ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .init_busy_i   (init_busy_i),
  .req_i         (req_i),
  .xfer_active_i (xfer_active_i),
  .breq_in_i     (breq_in_i),
  .arb_in_i      (arb_in_i),
  .grant_o       (grant_o),
  .breq_oe_o     (breq_oe_o),
  .arb_oe_o      (arb_oe_o)
);

// File: tb/wired_arb_agent_tb.sv
`timescale 1ns/1ps
module wired_arb_agent_tb;
  localparam int ID_W   = 5;
  localparam int SETTLE = 2;
  localparam int N_ID   = 1 << ID_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, init_busy, xfer;
  logic latch_a, latch_b, req_a, req_b;
  logic csm_en;
  logic [ID_W-1:0] csm_val;
  logic grant_a, grant_b, breq_oe_a, breq_oe_b, breq_out_a, breq_out_b;
  logic [ID_W-1:0] oe_a, oe_b, out_a, out_b, arb_lvl;
  logic breq_lvl;

  // wired-low bus model: low when any driver is enabled
  assign arb_lvl  = csm_en ? ~csm_val : ~(oe_a | oe_b);
  assign breq_lvl = ~(breq_oe_a | breq_oe_b);

  wired_arb_agent #(.ID_W(ID_W), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .init_busy_i(init_busy), .id_latch_i(latch_a),
    .req_i(req_a), .grant_o(grant_a), .xfer_active_i(xfer),
    .breq_in_i(breq_lvl), .breq_out_o(breq_out_a), .breq_oe_o(breq_oe_a),
    .arb_in_i(arb_lvl), .arb_out_o(out_a), .arb_oe_o(oe_a));

  wired_arb_agent #(.ID_W(ID_W), .SETTLE(SETTLE)) u_peer (
    .clk(clk), .rst(rst), .init_busy_i(init_busy), .id_latch_i(latch_b),
    .req_i(req_b), .grant_o(grant_b), .xfer_active_i(xfer),
    .breq_in_i(breq_lvl), .breq_out_o(breq_out_b), .breq_oe_o(breq_oe_b),
    .arb_in_i(arb_lvl), .arb_out_o(out_b), .arb_oe_o(oe_b));

  int checks = 0;
  int errors = 0;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_ids(input int a, input int b);
    @(negedge clk);
    init_busy = 1'b1; req_a = 1'b0; req_b = 1'b0; xfer = 1'b0;
    csm_en = 1'b1; csm_val = ID_W'(a); latch_a = 1'b1;
    @(negedge clk);
    latch_a = 1'b0; csm_val = ID_W'(b); latch_b = 1'b1;
    @(negedge clk);
    latch_b = 1'b0; csm_en = 1'b0; init_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic contest(input int a, input int b);
    bit a_wins;
    load_ids(a, b);
    a_wins = (a > b);
    req_a = 1'b1; req_b = 1'b1;
    @(negedge clk);
    check_eq("R4 breq a", int'(breq_oe_a), 1);
    check_eq("R4 breq b", int'(breq_oe_b), 1);
    repeat (SETTLE + 1) @(negedge clk);
    check_eq("R7 no early grant", int'(grant_a | grant_b), 0);
    @(negedge clk);
    check_eq("R6 grant a", int'(grant_a), int'(a_wins));
    check_eq("R6 grant b", int'(grant_b), int'(!a_wins));
    check_eq("R2 owner drive", int'(a_wins ? oe_a : oe_b), a_wins ? a : b);
    check_eq("R9 loser lines", int'(a_wins ? oe_b : oe_a), 0);
    check_eq("R9 loser breq", int'(a_wins ? breq_oe_b : breq_oe_a), 1);
    xfer = 1'b1;
    if (a_wins) req_a = 1'b0; else req_b = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R8 hold during xfer", int'(a_wins ? grant_a : grant_b), 1);
    xfer = 1'b0;
    @(negedge clk);
    check_eq("R8 release grant", int'(a_wins ? grant_a : grant_b), 0);
    check_eq("R8 release lines", int'(a_wins ? oe_a : oe_b), 0);
    check_eq("R8 release breq", int'(a_wins ? breq_oe_a : breq_oe_b), 0);
    repeat (SETTLE + 1) @(negedge clk);
    check_eq("R9 no early regrant", int'(a_wins ? grant_b : grant_a), 0);
    @(negedge clk);
    check_eq("R9 loser granted", int'(a_wins ? grant_b : grant_a), 1);
    check_eq("R9 loser drive", int'(a_wins ? oe_b : oe_a), a_wins ? b : a);
    if (a_wins) req_b = 1'b0; else req_a = 1'b0;
    @(negedge clk);
    check_eq("R8 loser release", int'(grant_a | grant_b), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; init_busy = 1'b0; xfer = 1'b0; latch_a = 1'b0; latch_b = 1'b0;
    req_a = 1'b0; req_b = 1'b0; csm_en = 1'b0; csm_val = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 grant", int'(grant_a | grant_b), 0);
    check_eq("R1 breq", int'(breq_oe_a | breq_oe_b), 0);
    check_eq("R1 lines", int'(oe_a | oe_b), 0);
    rst = 1'b0;

    // R3: requests ignored during initialisation
    init_busy = 1'b1; req_a = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R3 breq", int'(breq_oe_a), 0);
    check_eq("R3 grant", int'(grant_a), 0);
    req_a = 1'b0; init_busy = 1'b0;

    // R5: lone agent waits for transfer end, then wins
    load_ids(9, 3);
    xfer = 1'b1; req_a = 1'b1;
    @(negedge clk);
    check_eq("R4 lone breq", int'(breq_oe_a), 1);
    repeat (3) @(negedge clk);
    check_eq("R5 held off by xfer", int'(oe_a), 0);
    check_eq("R5 no grant during xfer", int'(grant_a), 0);
    xfer = 1'b0;
    repeat (SETTLE + 1) @(negedge clk);
    check_eq("R5 not yet granted", int'(grant_a), 0);
    @(negedge clk);
    check_eq("R5 granted", int'(grant_a), 1);
    check_eq("R2 captured id", int'(oe_a), 9);
    check_eq("R10 out values", int'(out_a | out_b) + int'(breq_out_a | breq_out_b), 0);
    req_a = 1'b0;
    @(negedge clk);
    check_eq("R8 lone release", int'(grant_a), 0);

    // R6: every ordered pair of distinct nonzero identifiers
    for (int a = 1; a < N_ID; a++) begin
      for (int b = 1; b < N_ID; b++) begin
        if (a != b) contest(a, b);
      end
    end
    check_eq("R10 out values end", int'(out_a | out_b) + int'(breq_out_a | breq_out_b), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule